// File: doc/BRIEF.md
# Zero-Overhead Hardware Loop Sequencer

This block sits beside the fetch stage of a program controller and repeats a block of code without spending any cycles on loop bookkeeping. A loop-start command supplies the address of the first instruction of the body, the address of the last instruction and an iteration count. The block keeps the last address and the remaining count in two registers. It keeps the body start address in a two-entry last-in-first-out stack, so one loop can nest inside another. Each time the fetch stage advances past the last instruction of the body with passes still remaining, the block tells the fetch stage in the same cycle to jump back to the start address.

A single loop-active flag shows whether any loop is running. A one-bit nesting flag records the loop-active value from before the most recent loop start, so leaving the inner loop can restore the outer loop's state. An explicit loop-exit command, or the natural end of the final pass, pops the stack and restores the flags. Stack misuse sets a sticky error flag and changes no loop state. Saving and restoring the end address and the count of an outer loop is left to software.

Top module: `hwloop_seq`

## Requirements
- R1: After reset, loopFlag, nestFlag and stackErr are 0, the stack is empty and pcRedirect is 0.
- R2: A loop start (doCmd=1) with a nonzero count and a stack that is not full pushes doStartAddr, loads doEndAddr as the loop end and doCount as the remaining count, and sets loopFlag on the next cycle.
- R3: On such a loop start, nestFlag takes the value loopFlag had before the start.
- R4: With loopFlag=1, fetchAdv=1, pcIn equal to the loop end and a remaining count above 1, pcRedirect is 1 in that same cycle with redirectPc equal to the top stack entry, and the count drops by one.
- R5: On the same condition with a remaining count of exactly 1, there is no redirect, the fetch falls through to the next address, the stack pops, loopFlag takes nestFlag's value and nestFlag clears.
- R6: A loop exit (endDoCmd=1) on a non-empty stack pops it, loopFlag takes nestFlag's value, nestFlag clears, and there is no redirect.
- R7: A loop start with a count of zero changes no loop state and, in the same cycle, redirects to doEndAddr+1.
- R8: A loop start when both stack entries are in use sets stackErr and leaves the stack, the loop end, the count and both flags unchanged.
- R9: A loop exit on an empty stack sets stackErr and leaves the stack and the flags unchanged.
- R10: Without fetchAdv, or with pcIn different from the loop end, there is no redirect and the count stays the same.
- R11: A loop start or loop exit in the same cycle as a loop-end fetch takes precedence. The loop-end evaluation is dropped: no redirect and no decrement. A start also takes precedence over a simultaneous exit.
- R12: stackErr stays 1 until reset.
- R13: The stack is last-in first-out. While two loops are active, loop-backs go to the inner start. After the inner loop is popped, they go to the outer start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pcIn | input | 16 | Address currently being fetched |
| fetchAdv | input | 1 | Fetch advances past pcIn this cycle |
| doCmd | input | 1 | Loop start command |
| doStartAddr | input | 16 | First instruction of the loop body |
| doEndAddr | input | 16 | Last instruction of the loop body |
| doCount | input | 16 | Number of passes |
| endDoCmd | input | 1 | Loop exit command |
| pcRedirect | output | 1 | Override the next fetch address this cycle |
| redirectPc | output | 16 | Override address, valid when pcRedirect=1 |
| loopFlag | output | 1 | A loop is active |
| nestFlag | output | 1 | The loop-active value saved at the last start |
| stackErr | output | 1 | Sticky stack overflow or underflow |

## Verification
A loop-end fetch can coincide with a loop exit command. Both would pop the stack, and the loop-end fetch would also redirect. The bench starts a two-pass loop and then drives endDoCmd in the same cycle that pcIn equals the loop end with fetchAdv high. It expects no redirect, a single pop and loopFlag back to 0. A second coincidence is a nested-loop exit followed by a loop-end hit that must land on the outer start address, which shows the LIFO order is kept.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;
  // Strobes from the sequencing control to the loop datapath
  typedef struct packed {
    logic push;      // store a new start address on top
    logic pop;       // discard the top entry
    logic load;      // capture end address and pass count
    logic dec;       // one pass consumed
    logic redirTop;  // jump back to the top stack entry
    logic redirSkip; // skip a zero-pass body
    logic setErr;    // stack misuse
  } loopStrb_t;
endpackage

// File: rtl/hwloop_seq_dp.sv
module hwloop_seq_dp
  import hwloop_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  loopStrb_t     strb,
  input  logic [AW-1:0] pcIn,
  input  logic [AW-1:0] doStartAddr,
  input  logic [AW-1:0] doEndAddr,
  input  logic [CW-1:0] doCount,
  output logic          atEnd,
  output logic          countGtOne,
  output logic          stackFull,
  output logic          stackEmpty,
  output logic          pcRedirect,
  output logic [AW-1:0] redirectPc
);
  localparam int DCW = $clog2(DEPTH + 1);
  localparam logic [DCW-1:0] FULL_CNT = DCW'(DEPTH);

  logic [AW-1:0]  loopEnd;
  logic [CW-1:0]  passLeft;
  logic [DCW-1:0] depthCnt;
  logic [AW-1:0]  stk [DEPTH];

  // Shift-register stack: entry 0 is always the top
  for (genvar i = 0; i < DEPTH; i++) begin : g_stk
    logic [AW-1:0] fromAbove;
    logic [AW-1:0] fromBelow;
    if (i == 0) begin : g_top
      assign fromAbove = doStartAddr;
    end else begin : g_mid
      assign fromAbove = stk[i-1];
    end
    if (i == DEPTH - 1) begin : g_last
      assign fromBelow = '0;
    end else begin : g_inner
      assign fromBelow = stk[i+1];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         stk[i] <= '0;
      else if (strb.push) stk[i] <= fromAbove;
      else if (strb.pop)  stk[i] <= fromBelow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          depthCnt <= '0;
    else if (strb.push) depthCnt <= depthCnt + 1'b1;
    else if (strb.pop)  depthCnt <= depthCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopEnd  <= '0;
      passLeft <= '0;
    end else if (strb.load) begin
      loopEnd  <= doEndAddr;
      passLeft <= doCount;
    end else if (strb.dec) begin
      passLeft <= passLeft - 1'b1;
    end
  end

  assign atEnd      = (pcIn == loopEnd);
  assign countGtOne = (passLeft > CW'(1));
  assign stackFull  = (depthCnt == FULL_CNT);
  assign stackEmpty = (depthCnt == '0);
  assign pcRedirect = strb.redirTop | strb.redirSkip;
  assign redirectPc = strb.redirTop ? stk[0] : doEndAddr + 1'b1;

  // Loop-back only happens at the end address with passes left
  assert_redir_at_end_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.redirTop |-> (atEnd && countGtOne && !stackEmpty));
  // Overflow or underflow leaves stack depth and top entry alone
  assert_err_keeps_stack_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.setErr |=> (depthCnt == $past(depthCnt) && stk[0] == $past(stk[0])));
  // Zero-pass start never loads or pushes
  assert_skip_no_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.redirSkip |-> (!strb.load && !strb.push));
  // Never push a full stack nor pop an empty one
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.push && stackFull) && !(strb.pop && stackEmpty));
endmodule

// File: rtl/hwloop_seq_ctrl.sv
module hwloop_seq_ctrl
  import hwloop_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fetchAdv,
  input  logic          doCmd,
  input  logic [CW-1:0] doCount,
  input  logic          endDoCmd,
  input  logic          atEnd,
  input  logic          countGtOne,
  input  logic          stackFull,
  input  logic          stackEmpty,
  output loopStrb_t     strb,
  output logic          loopFlag,
  output logic          nestFlag,
  output logic          stackErr
);
  logic endHit;
  assign endHit = loopFlag && fetchAdv && atEnd;

  // Priority: loop start, then loop exit, then loop-end fetch
  always_comb begin
    strb = '0;
    if (doCmd) begin
      if (doCount == '0)   strb.redirSkip = 1'b1;
      else if (stackFull)  strb.setErr    = 1'b1;
      else begin
        strb.push = 1'b1;
        strb.load = 1'b1;
      end
    end else if (endDoCmd) begin
      if (stackEmpty) strb.setErr = 1'b1;
      else            strb.pop    = 1'b1;
    end else if (endHit) begin
      if (countGtOne) begin
        strb.redirTop = 1'b1;
        strb.dec      = 1'b1;
      end else if (stackEmpty) begin
        strb.setErr = 1'b1;
      end else begin
        strb.pop = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loopFlag <= 1'b0;
      nestFlag <= 1'b0;
    end else if (strb.push) begin
      nestFlag <= loopFlag;
      loopFlag <= 1'b1;
    end else if (strb.pop) begin
      loopFlag <= nestFlag;
      nestFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            stackErr <= 1'b0;
    else if (strb.setErr) stackErr <= 1'b1;
  end

  // Loop flag mirrors whether the datapath stack holds anything
  assert_flag_tracks_stack_R2: assert property (@(posedge clk) disable iff (!rstN)
    loopFlag == !stackEmpty);
  assert_nest_copy_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |=> (nestFlag == $past(loopFlag)));
  assert_pop_restore_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |=> (loopFlag == $past(nestFlag) && !nestFlag));
  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |=> stackErr);
  assert_cmd_first_R11: assert property (@(posedge clk) disable iff (!rstN)
    (doCmd || endDoCmd) |-> (!strb.redirTop && !strb.dec));
  assert_idle_fetch_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!fetchAdv || !atEnd) |-> !strb.redirTop);
  assert_one_redirect_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.redirTop, strb.redirSkip}));
endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
  import hwloop_pkg::*;
#(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] pcIn,
  input  logic          fetchAdv,
  input  logic          doCmd,
  input  logic [AW-1:0] doStartAddr,
  input  logic [AW-1:0] doEndAddr,
  input  logic [CW-1:0] doCount,
  input  logic          endDoCmd,
  output logic          pcRedirect,
  output logic [AW-1:0] redirectPc,
  output logic          loopFlag,
  output logic          nestFlag,
  output logic          stackErr
);
  loopStrb_t strb;
  logic atEnd, countGtOne, stackFull, stackEmpty;

  hwloop_seq_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchAdv(fetchAdv), .doCmd(doCmd),
    .doCount(doCount), .endDoCmd(endDoCmd), .atEnd(atEnd),
    .countGtOne(countGtOne), .stackFull(stackFull), .stackEmpty(stackEmpty),
    .strb(strb), .loopFlag(loopFlag), .nestFlag(nestFlag), .stackErr(stackErr)
  );

  hwloop_seq_dp #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pcIn(pcIn),
    .doStartAddr(doStartAddr), .doEndAddr(doEndAddr), .doCount(doCount),
    .atEnd(atEnd), .countGtOne(countGtOne), .stackFull(stackFull),
    .stackEmpty(stackEmpty), .pcRedirect(pcRedirect), .redirectPc(redirectPc)
  );
endmodule

// File: tb/hwloop_seq_tb.sv
module hwloop_seq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pcIn = '0;
  logic        fetchAdv = 1'b0;
  logic        doCmd = 1'b0;
  logic [15:0] doStartAddr = '0;
  logic [15:0] doEndAddr = '0;
  logic [15:0] doCount = '0;
  logic        endDoCmd = 1'b0;
  logic        pcRedirect;
  logic [15:0] redirectPc;
  logic        loopFlag, nestFlag, stackErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    logic       eRed;
    logic [15:0] ePc;
    logic       eLf;
    logic       eNl;
    logic       eErr;
  } expItem_t;

  expItem_t q[$];

  always #4 clk = ~clk; // 125 MHz

  hwloop_seq u_dut (
    .clk(clk), .rstN(rstN), .pcIn(pcIn), .fetchAdv(fetchAdv), .doCmd(doCmd),
    .doStartAddr(doStartAddr), .doEndAddr(doEndAddr), .doCount(doCount),
    .endDoCmd(endDoCmd), .pcRedirect(pcRedirect), .redirectPc(redirectPc),
    .loopFlag(loopFlag), .nestFlag(nestFlag), .stackErr(stackErr)
  );

  task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue what must come out
  task automatic step(logic dC, logic [15:0] st, logic [15:0] en, logic [15:0] cnt,
                      logic eC, logic adv, logic [15:0] pc,
                      logic eRed, logic [15:0] ePc, logic eLf, logic eNl, logic eErr,
                      string req);
    expItem_t it;
    @(negedge clk);
    doCmd = dC; doStartAddr = st; doEndAddr = en; doCount = cnt;
    endDoCmd = eC; fetchAdv = adv; pcIn = pc;
    it.req = req; it.eRed = eRed; it.ePc = ePc;
    it.eLf = eLf; it.eNl = eNl; it.eErr = eErr;
    q.push_back(it);
  endtask

  task automatic fetch(logic [15:0] pc, logic eRed, logic [15:0] ePc,
                       logic eLf, logic eNl, logic eErr, string req);
    step(0, 0, 0, 0, 0, 1, pc, eRed, ePc, eLf, eNl, eErr, req);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(posedge clk);
    #2;
    doCmd = 0; endDoCmd = 0; fetchAdv = 0;
  endtask

  task automatic doReset();
    drain();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  // Monitor: pop expectations and compare with the design
  initial begin
    expItem_t it;
    forever begin
      @(negedge clk);
      #3;
      if (q.size() != 0) begin
        it = q.pop_front();
        check(it.req, "pcRedirect", 16'(pcRedirect), 16'(it.eRed));
        if (it.eRed) check(it.req, "redirectPc", redirectPc, it.ePc);
        @(posedge clk);
        #1;
        check(it.req, "loopFlag", 16'(loopFlag), 16'(it.eLf));
        check(it.req, "nestFlag", 16'(nestFlag), 16'(it.eNl));
        check(it.req, "stackErr", 16'(stackErr), 16'(it.eErr));
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    // R1: idle after reset
    fetch(16'h0000, 0, 0, 0, 0, 0, "R1");
    // R2: single loop start, three passes over 0x10..0x12
    step(1, 16'h0010, 16'h0012, 16'd3, 0, 0, 0, 0, 0, 1, 0, 0, "R2");
    fetch(16'h0010, 0, 0, 1, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 16'h0012, 0, 0, 1, 0, 0, "R10");   // no advance
    fetch(16'h0012, 1, 16'h0010, 1, 0, 0, "R4");
    fetch(16'h0012, 1, 16'h0010, 1, 0, 0, "R4");
    fetch(16'h0012, 0, 0, 0, 0, 0, "R5");                     // last pass
    // R7: zero passes skip past the body
    step(1, 16'h0020, 16'h002F, 16'd0, 0, 0, 0, 1, 16'h0030, 0, 0, 0, "R7");
    fetch(16'h002F, 0, 0, 0, 0, 0, "R7");
    // R3 / R13: nested loops
    step(1, 16'h0100, 16'h0110, 16'd5, 0, 0, 0, 0, 0, 1, 0, 0, "R2");
    step(1, 16'h0200, 16'h0205, 16'd3, 0, 0, 0, 0, 0, 1, 1, 0, "R3");
    fetch(16'h0205, 1, 16'h0200, 1, 1, 0, "R13");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0, "R6");
    fetch(16'h0205, 1, 16'h0100, 1, 0, 0, "R13");
    fetch(16'h0205, 0, 0, 0, 0, 0, "R5");
    // R11: exit coincides with loop-end fetch
    step(1, 16'h0040, 16'h0044, 16'd2, 0, 0, 0, 0, 0, 1, 0, 0, "R2");
    step(0, 0, 0, 0, 1, 1, 16'h0044, 0, 0, 0, 0, 0, "R11");
    // R8: third start on a full stack
    step(1, 16'h0050, 16'h0058, 16'd4, 0, 0, 0, 0, 0, 1, 0, 0, "R2");
    step(1, 16'h0060, 16'h0068, 16'd4, 0, 0, 0, 0, 0, 1, 1, 0, "R3");
    step(1, 16'h0070, 16'h0078, 16'd4, 0, 0, 0, 0, 0, 1, 1, 1, "R8");
    fetch(16'h0078, 0, 0, 1, 1, 1, "R8");                      // end not replaced
    fetch(16'h0068, 1, 16'h0060, 1, 1, 1, "R8");               // top not replaced
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 0, 1, "R12");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, "R12");
    // R9: exit on an empty stack
    doReset();
    fetch(16'h0000, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, "R9");
    fetch(16'h0000, 0, 0, 0, 0, 1, "R12");
    step(1, 16'h0080, 16'h0081, 16'd2, 0, 0, 0, 0, 0, 1, 0, 1, "R9");
    fetch(16'h0081, 1, 16'h0080, 1, 0, 1, "R9");
    fetch(16'h0081, 0, 0, 0, 0, 1, "R5");
    // R12: only reset clears the error
    doReset();
    fetch(16'h0000, 0, 0, 0, 0, 0, "R12");
    drain();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule